// File: doc/BRIEF.md
# Single-Cycle Load/Store Integer Core

This block is a 32-bit processor core that completes one instruction per clock. In each cycle it presents the program counter on the instruction port and takes the returned word in the same cycle. It decodes the word, reads two operands from a 32-entry register file, and computes an arithmetic, logic, shift or compare result, or a memory address. It then writes the result back and selects the next program counter. Both memory ports are combinational reads: the surrounding logic returns the instruction word and the load data within the same cycle. Stores are committed at the next rising clock edge.

The core handles a fixed subset of operations in three word shapes: register-register, register-immediate and long jump. The register-register, register-immediate and jump shapes place opcode, source, target, destination, shift amount and function code at fixed bit positions. Register 0 is hardwired to zero. The core has no pipeline, so no hazard logic is needed. Any word it does not recognise acts as a no-op.

Top module: `rcore_top`

## Requirements
- R1: While `rst_n` is low, `imem_addr` is 0 and `dmem_we` is 0, and every register holds zero. After reset, each instruction that is not a branch, jump or register jump advances `imem_addr` by 4 at the next clock.
- R2: Register 0 always reads as zero. A write whose destination is register 0 leaves it at zero.
- R3: Opcode 000000 selects the register-register shape, with rs at [25:21], rt at [20:16], rd at [15:11], shift amount at [10:6] and function at [5:0]. Function 100000 writes rs+rt to rd and function 100010 writes rs-rt to rd. Both wrap modulo 2^32.
- R4: Functions 100100, 100101 and 100111 write rs AND rt, rs OR rt and NOT(rs OR rt) to rd.
- R5: Function 000000 writes rt shifted left by the shift amount to rd. Function 000010 writes rt shifted right logically, filling with zeros.
- R6: Function 101010 writes 1 to rd when rs is less than rt as signed two's-complement numbers, and 0 otherwise.
- R7: In the immediate shape, imm is at [15:0] and the destination is rt. Opcode 001000 adds the sign-extended imm to rs. Opcodes 001100 and 001101 AND and OR rs with the zero-extended imm.
- R8: Opcode 100011 drives `dmem_addr` with rs plus the sign-extended imm and writes `dmem_rdata` into rt.
- R9: Opcode 101011 raises `dmem_we` with `dmem_addr` equal to rs plus the sign-extended imm and `dmem_wdata` equal to rt, and writes no register. No other instruction raises `dmem_we`.
- R10: Opcode 000100 (taken when rs equals rt) and opcode 000101 (taken when they differ) load PC+4 plus the sign-extended imm times 4 when taken, and PC+4 otherwise.
- R11: Opcode 000010 loads {PC+4[31:28], word[25:0], 00}. Function 001000 in the register shape loads the value of rs.
- R12: An unknown opcode, or an unknown function under opcode 000000, changes no register, raises no store and advances the PC by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Byte address for load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store strobe, committed at the next rising edge |
| dmem_rdata | input | 32 | Load data at `dmem_addr`, same cycle |

## Verification
A wrong program counter shows on `imem_addr` at the very next clock. A faulty branch, jump or sequential step therefore appears within one cycle. A wrong register value is hidden until an instruction carries it to a port. That happens when a store places it on `dmem_wdata` or an address computation places it on `dmem_addr`. The stimulus therefore stores every result a few cycles after computing it, and stores register 0 after a write to it. A spurious or missing store shows on `dmem_we` in the cycle of the offending instruction.

// File: rtl/rcore_pkg.sv
package rcore_pkg;

    localparam int XLEN   = 32;
    localparam int NREGS  = 32;
    localparam int RIDX_W = $clog2(NREGS);

    localparam logic [5:0] OPC_REG  = 6'b000000;
    localparam logic [5:0] OPC_ADDI = 6'b001000;
    localparam logic [5:0] OPC_ANDI = 6'b001100;
    localparam logic [5:0] OPC_ORI  = 6'b001101;
    localparam logic [5:0] OPC_LW   = 6'b100011;
    localparam logic [5:0] OPC_SW   = 6'b101011;
    localparam logic [5:0] OPC_BEQ  = 6'b000100;
    localparam logic [5:0] OPC_BNE  = 6'b000101;
    localparam logic [5:0] OPC_J    = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_NOR = 6'b100111;
    localparam logic [5:0] FN_SLT = 6'b101010;
    localparam logic [5:0] FN_SLL = 6'b000000;
    localparam logic [5:0] FN_SRL = 6'b000010;
    localparam logic [5:0] FN_JR  = 6'b001000;

    typedef enum logic [4:0] {
        K_NOP, K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLT, K_SLL, K_SRL, K_JR,
        K_ADDI, K_ANDI, K_ORI, K_LW, K_SW, K_BEQ, K_BNE, K_J
    } kind_e;

    typedef struct packed {
        kind_e             kind;
        logic [RIDX_W-1:0] rs;
        logic [RIDX_W-1:0] rt;
        logic [RIDX_W-1:0] wsel;
        logic [4:0]        shamt;
        logic              wen;
        logic [XLEN-1:0]   imm;
        logic [25:0]       jidx;
    } dec_t;

endpackage

// File: rtl/rcore_decode.sv
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    logic [5:0] opc;
    logic [5:0] fn;

    assign opc = instr[31:26];
    assign fn  = instr[5:0];

    always_comb begin
        dec.kind  = K_NOP;
        dec.rs    = instr[25:21];
        dec.rt    = instr[20:16];
        dec.wsel  = instr[15:11];
        dec.shamt = instr[10:6];
        dec.wen   = 1'b0;
        dec.imm   = {{(XLEN-16){instr[15]}}, instr[15:0]};
        dec.jidx  = instr[25:0];
        unique case (opc)
            OPC_REG: begin
                dec.wen = 1'b1;
                unique case (fn)
                    FN_ADD:  dec.kind = K_ADD;
                    FN_SUB:  dec.kind = K_SUB;
                    FN_AND:  dec.kind = K_AND;
                    FN_OR:   dec.kind = K_OR;
                    FN_NOR:  dec.kind = K_NOR;
                    FN_SLT:  dec.kind = K_SLT;
                    FN_SLL:  dec.kind = K_SLL;
                    FN_SRL:  dec.kind = K_SRL;
                    FN_JR: begin
                        dec.kind = K_JR;
                        dec.wen  = 1'b0;
                    end
                    default: dec.wen = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                dec.kind = K_ADDI;
                dec.wen  = 1'b1;
                dec.wsel = instr[20:16];
            end
            OPC_ANDI, OPC_ORI: begin
                dec.kind = (opc == OPC_ANDI) ? K_ANDI : K_ORI;
                dec.wen  = 1'b1;
                dec.wsel = instr[20:16];
                dec.imm  = {{(XLEN-16){1'b0}}, instr[15:0]};
            end
            OPC_LW: begin
                dec.kind = K_LW;
                dec.wen  = 1'b1;
                dec.wsel = instr[20:16];
            end
            OPC_SW:  dec.kind = K_SW;
            OPC_BEQ: dec.kind = K_BEQ;
            OPC_BNE: dec.kind = K_BNE;
            OPC_J:   dec.kind = K_J;
            default: dec.kind = K_NOP;
        endcase
    end

endmodule

// File: rtl/rcore_regs.sv
module rcore_regs #(
    parameter int DW    = 32,
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(DEPTH)-1:0] ra_idx,
    output logic [DW-1:0]            ra_data,
    input  logic [$clog2(DEPTH)-1:0] rb_idx,
    output logic [DW-1:0]            rb_data,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] w_idx,
    input  logic [DW-1:0]            w_data
);

    localparam int AW = $clog2(DEPTH);

    logic [DEPTH-1:0][DW-1:0] bank;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank <= '0;
        end else if (we && (w_idx != AW'(0))) begin
            bank[w_idx] <= w_data;
        end
    end

    assign ra_data = (ra_idx == AW'(0)) ? '0 : bank[ra_idx];
    assign rb_data = (rb_idx == AW'(0)) ? '0 : bank[rb_idx];

endmodule

// File: rtl/rcore_alu.sv
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = 32
) (
    input  kind_e        kind,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] imm,
    input  logic [4:0]   shamt,
    output logic [W-1:0] y
);

    logic [W-1:0] rhs;

    always_comb begin
        rhs = (kind inside {K_ADDI, K_ANDI, K_ORI, K_LW, K_SW}) ? imm : b;
        unique case (kind)
            K_ADD, K_ADDI, K_LW, K_SW: y = a + rhs;
            K_SUB:                     y = a - rhs;
            K_AND, K_ANDI:             y = a & rhs;
            K_OR, K_ORI:               y = a | rhs;
            K_NOR:                     y = ~(a | rhs);
            K_SLT:                     y = {{(W-1){1'b0}}, ($signed(a) < $signed(rhs))};
            K_SLL:                     y = b << shamt;
            K_SRL:                     y = b >> shamt;
            default:                   y = '0;
        endcase
    end

endmodule

// File: rtl/rcore_nextpc.sv
module rcore_nextpc
    import rcore_pkg::*;
(
    input  kind_e           kind,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [XLEN-1:0] imm,
    input  logic [25:0]     jidx,
    output logic [XLEN-1:0] npc
);

    logic [XLEN-1:0] pc_inc;
    logic [XLEN-1:0] br_tgt;
    logic            same;

    assign pc_inc = pc + XLEN'(4);
    assign br_tgt = pc_inc + (imm << 2);
    assign same   = (rs_val == rt_val);

    always_comb begin
        unique case (kind)
            K_BEQ:   npc = same ? br_tgt : pc_inc;
            K_BNE:   npc = same ? pc_inc : br_tgt;
            K_J:     npc = {pc_inc[XLEN-1:XLEN-4], jidx, 2'b00};
            K_JR:    npc = rs_val;
            default: npc = pc_inc;
        endcase
    end

endmodule

// File: rtl/rcore_top.sv
module rcore_top
    import rcore_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_d;
    dec_t            dec;
    logic [XLEN-1:0] rs_val;
    logic [XLEN-1:0] rt_val;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] wb_data;

    rcore_decode u_dec (
        .instr (imem_data),
        .dec   (dec)
    );

    rcore_regs #(.DW(XLEN), .DEPTH(NREGS)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (dec.rs),
        .ra_data (rs_val),
        .rb_idx  (dec.rt),
        .rb_data (rt_val),
        .we      (dec.wen),
        .w_idx   (dec.wsel),
        .w_data  (wb_data)
    );

    rcore_alu #(.W(XLEN)) u_alu (
        .kind  (dec.kind),
        .a     (rs_val),
        .b     (rt_val),
        .imm   (dec.imm),
        .shamt (dec.shamt),
        .y     (alu_y)
    );

    rcore_nextpc u_npc (
        .kind   (dec.kind),
        .pc     (pc_q),
        .rs_val (rs_val),
        .rt_val (rt_val),
        .imm    (dec.imm),
        .jidx   (dec.jidx),
        .npc    (pc_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

    assign wb_data    = (dec.kind == K_LW) ? dmem_rdata : alu_y;
    assign imem_addr  = pc_q;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;
    assign dmem_we    = rst_n && (dec.kind == K_SW);

    AST_PC_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dec.kind inside {K_BEQ, K_BNE, K_J, K_JR}) |=> imem_addr == $past(imem_addr) + 32'd4); // R1

    AST_STORE_ONLY_SW: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we |-> (imem_data[31:26] == OPC_SW)); // R9

    AST_NOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_NOP) |-> (!dec.wen && !dmem_we)); // R12

    AST_SLT_EQUAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_SLT && rs_val == rt_val) |-> (alu_y == '0)); // R6

    AST_BEQ_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dec.kind == K_BEQ && rs_val == rt_val)
        |=> imem_addr == $past(imem_addr) + 32'd4 + ($past(dec.imm) << 2)); // R10

endmodule

// File: tb/rcore_top_tb.sv
module rcore_top_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [64];
    logic [31:0] dmem [64];

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    assign imem_data  = imem[imem_addr[7:2]];
    assign dmem_rdata = dmem[dmem_addr[7:2]];

    rcore_top u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    // reference model state
    logic [31:0] m_r [32];
    logic [31:0] m_mem [64];
    string       m_tag [32];
    logic [31:0] m_pc;
    string       pc_tag;

    logic [31:0] ins, a, b, simm, zimm, npc, wval, ea;
    logic [5:0]  opc, fn;
    logic [4:0]  rs, rt, rd, sh, wdst;
    bit          do_w, st, ld;
    string       tag;

    task automatic chk(input bit ok, input string t, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", t, act, exp);
        end
    endtask

    function automatic logic [31:0] rw(logic [4:0] s, logic [4:0] t, logic [4:0] d, logic [4:0] h, logic [5:0] f);
        return {6'b000000, s, t, d, h, f};
    endfunction

    function automatic logic [31:0] iw(logic [5:0] o, logic [4:0] s, logic [4:0] t, logic [15:0] k);
        return {o, s, t, k};
    endfunction

    task automatic model_step();
        ins  = imem[m_pc[7:2]];
        opc  = ins[31:26]; fn = ins[5:0];
        rs   = ins[25:21]; rt = ins[20:16]; rd = ins[15:11]; sh = ins[10:6];
        a    = m_r[rs]; b = m_r[rt];
        simm = {{16{ins[15]}}, ins[15:0]};
        zimm = {16'h0000, ins[15:0]};
        ea   = a + simm;
        npc  = m_pc + 32'd4;
        do_w = 1'b0; st = 1'b0; ld = 1'b0; wdst = 5'd0; wval = 32'd0; tag = "R12";
        case (opc)
            6'h00: case (fn)
                6'h20: begin do_w = 1; wdst = rd; wval = a + b; tag = "R3"; end
                6'h22: begin do_w = 1; wdst = rd; wval = a - b; tag = "R3"; end
                6'h24: begin do_w = 1; wdst = rd; wval = a & b; tag = "R4"; end
                6'h25: begin do_w = 1; wdst = rd; wval = a | b; tag = "R4"; end
                6'h27: begin do_w = 1; wdst = rd; wval = ~(a | b); tag = "R4"; end
                6'h2A: begin do_w = 1; wdst = rd; wval = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0; tag = "R6"; end
                6'h00: begin do_w = 1; wdst = rd; wval = b << sh; tag = "R5"; end
                6'h02: begin do_w = 1; wdst = rd; wval = b >> sh; tag = "R5"; end
                6'h08: begin npc = a; tag = "R11"; end
                default: ;
            endcase
            6'h08: begin do_w = 1; wdst = rt; wval = a + simm; tag = "R7"; end
            6'h0C: begin do_w = 1; wdst = rt; wval = a & zimm; tag = "R7"; end
            6'h0D: begin do_w = 1; wdst = rt; wval = a | zimm; tag = "R7"; end
            6'h23: begin do_w = 1; ld = 1; wdst = rt; wval = m_mem[ea[7:2]]; tag = "R8"; end
            6'h2B: begin st = 1; tag = "R9"; end
            6'h04: begin if (a == b) npc = m_pc + 32'd4 + (simm << 2); tag = "R10"; end
            6'h05: begin if (a != b) npc = m_pc + 32'd4 + (simm << 2); tag = "R10"; end
            6'h02: begin npc = {npc[31:28], ins[25:0], 2'b00}; tag = "R11"; end
            default: ;
        endcase

        chk(imem_addr === m_pc, pc_tag, imem_addr, m_pc);
        chk(dmem_we === st, st ? "R9" : tag, {31'b0, dmem_we}, {31'b0, st});
        if (st) begin
            chk(dmem_addr === ea, "R9", dmem_addr, ea);
            chk(dmem_wdata === b, m_tag[rt], dmem_wdata, b);
        end
        if (ld) chk(dmem_addr === ea, "R8", dmem_addr, ea);

        if (dmem_we) dmem[dmem_addr[7:2]] = dmem_wdata;

        if (st) m_mem[ea[7:2]] = b;
        if (do_w) begin
            if (wdst != 5'd0) m_r[wdst] = wval;
            m_tag[wdst] = (wdst == 5'd0) ? "R2" : tag;
        end
        if (tag == "R12") begin
            if (rt != 5'd0) m_tag[rt] = "R12";
            if (rd != 5'd0) m_tag[rd] = "R12";
        end
        pc_tag = (tag == "R10" || tag == "R11" || tag == "R12") ? tag : "R1";
        m_pc   = npc;
    endtask

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 32'h0;
            dmem[i] = 32'h13579BDF ^ (32'(i) * 32'h01010101);
        end
        dmem[5] = 32'hCAFEF00D;
        for (int i = 0; i < 64; i++) m_mem[i] = dmem[i];
        for (int i = 0; i < 32; i++) begin m_r[i] = 32'h0; m_tag[i] = "R1"; end
        m_tag[0] = "R2";
        m_pc   = 32'h0;
        pc_tag = "R1";

        imem[0]  = iw(6'h2B, 5'd0, 5'd0, 16'h0080);   // store zero register right after reset
        imem[1]  = iw(6'h08, 5'd0, 5'd1, 16'hFFFB);   // R7 sign extension
        imem[2]  = iw(6'h0D, 5'd0, 5'd2, 16'h8001);   // R7 zero extension
        imem[3]  = iw(6'h0C, 5'd1, 5'd3, 16'hF0F0);
        imem[4]  = rw(5'd1, 5'd2, 5'd4, 5'd0, 6'h20);
        imem[5]  = rw(5'd1, 5'd2, 5'd5, 5'd0, 6'h22);
        imem[6]  = rw(5'd1, 5'd2, 5'd6, 5'd0, 6'h24);
        imem[7]  = rw(5'd1, 5'd2, 5'd7, 5'd0, 6'h25);
        imem[8]  = rw(5'd1, 5'd0, 5'd8, 5'd0, 6'h27);  // R4 NOT via nor with zero
        imem[9]  = rw(5'd0, 5'd2, 5'd9, 5'd4, 6'h00);
        imem[10] = rw(5'd0, 5'd1, 5'd10, 5'd28, 6'h02); // R5 logical fill
        imem[11] = rw(5'd1, 5'd2, 5'd11, 5'd0, 6'h2A);  // R6 negative < positive
        imem[12] = rw(5'd2, 5'd1, 5'd12, 5'd0, 6'h2A);
        imem[13] = iw(6'h0D, 5'd0, 5'd13, 16'h7FFF);
        imem[14] = rw(5'd0, 5'd13, 5'd13, 5'd16, 6'h00);
        imem[15] = rw(5'd13, 5'd13, 5'd14, 5'd0, 6'h20); // R3 wrap
        imem[16] = iw(6'h08, 5'd0, 5'd0, 16'h0005);      // R2 write to zero
        imem[17] = iw(6'h08, 5'd0, 5'd21, 16'hFFFC);
        imem[18] = iw(6'h23, 5'd21, 5'd15, 16'h0018);    // R8 load from 0x14
        for (int k = 1; k <= 15; k++)
            imem[18+k] = iw(6'h2B, 5'd0, 5'(k), 16'(32'h84 + 4*(k-1)));
        imem[34] = iw(6'h2B, 5'd0, 5'd0, 16'h00C0);
        imem[35] = iw(6'h04, 5'd1, 5'd2, 16'h0001);      // R10 beq not taken
        imem[36] = iw(6'h08, 5'd16, 5'd16, 16'h0001);
        imem[37] = iw(6'h04, 5'd1, 5'd1, 16'h0001);      // R10 beq taken
        imem[38] = iw(6'h08, 5'd16, 5'd16, 16'h0010);
        imem[39] = iw(6'h05, 5'd1, 5'd2, 16'h0001);      // R10 bne taken
        imem[40] = iw(6'h08, 5'd16, 5'd16, 16'h0100);
        imem[41] = iw(6'h05, 5'd1, 5'd1, 16'h0001);      // R10 bne not taken
        imem[42] = iw(6'h08, 5'd16, 5'd16, 16'h1000);
        imem[43] = iw(6'h2B, 5'd0, 5'd16, 16'h00C4);
        imem[44] = iw(6'h08, 5'd0, 5'd17, 16'h0003);
        imem[45] = iw(6'h08, 5'd17, 5'd17, 16'hFFFF);
        imem[46] = iw(6'h05, 5'd17, 5'd0, 16'hFFFE);     // R10 backward loop
        imem[47] = iw(6'h2B, 5'd0, 5'd17, 16'h00C8);
        imem[48] = iw(6'h3F, 5'd1, 5'd1, 16'h1234);      // R12 unknown opcode
        imem[49] = rw(5'd1, 5'd1, 5'd2, 5'd0, 6'h3F);    // R12 unknown function
        imem[50] = iw(6'h2B, 5'd0, 5'd1, 16'h00CC);
        imem[51] = iw(6'h2B, 5'd0, 5'd2, 16'h00D0);
        imem[52] = {6'h02, 26'd54};                      // R11 jump
        imem[53] = iw(6'h08, 5'd0, 5'd18, 16'h0007);
        imem[54] = iw(6'h08, 5'd0, 5'd19, 16'h00E4);
        imem[55] = rw(5'd19, 5'd0, 5'd0, 5'd0, 6'h08);   // R11 register jump
        imem[56] = iw(6'h08, 5'd18, 5'd18, 16'h0009);
        imem[57] = iw(6'h2B, 5'd0, 5'd18, 16'h00D4);
        imem[58] = {6'h02, 26'd58};

        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        chk(imem_addr === 32'h0, "R1", imem_addr, 32'h0);
        chk(dmem_we === 1'b0, "R1", {31'b0, dmem_we}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int cyc = 0; cyc < 90; cyc++) begin
            #1;
            model_step();
            @(negedge clk);
        end
        for (int i = 0; i < 64; i++)
            chk(dmem[i] === m_mem[i], "R9", dmem[i], m_mem[i]);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog R1 actual=%08h expected=%08h", imem_addr, m_pc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule